// File: doc/BRIEF.md
# Multi-Format Serial Line Encoder

The encoder turns a serial bit stream into one of five polar line codes: level-coded NRZ, inverting NRZ, three-level return-to-zero, Manchester, and differential Manchester. It runs from a clock at twice the bit rate, so every bit occupies two clock cycles, a first half and a second half. This lets the line level change in the middle of a bit.

A bit enters when the strobe input is high at a clock edge. The data bit and the format code are both sampled at that edge. The symbol for the first half appears after that edge, and the symbol for the second half appears after the next edge. The output is a two-bit signed symbol, together with a flag that says which half of the bit is on the line. Inverting NRZ and differential Manchester depend on the level sent before. These two formats share one stored reference level.

Top module: `line_encoder`

## Requirements
- R1: While reset is low, and after it, until the first strobe, `line_sym` is 2'b00 and `half_ph` is 1. Reset sets the stored reference level to positive, so an inverting-NRZ 0 bit sent first drives +1.
- R2: Symbols are encoded +1 = 2'b01, 0 = 2'b00, -1 = 2'b11, and 2'b10 never appears. A strobe at edge k puts the first-half symbol on the line with `half_ph` = 0 after edge k. The second-half symbol, with `half_ph` = 1, appears after edge k+1.
- R3: Format code 0 (level NRZ): a 0 bit drives +1 and a 1 bit drives -1 for both halves. Codes 5, 6 and 7 behave the same way.
- R4: Format code 1 (inverting NRZ): a 1 bit flips the level and a 0 bit keeps it. The new level holds for both halves.
- R5: Format code 2 (return-to-zero): the first half is +1 for a 1 bit and -1 for a 0 bit. The second half is 0.
- R6: Format code 3 (Manchester): a 1 bit is +1 then -1, and a 0 bit is -1 then +1.
- R7: Format code 4 (differential Manchester): a 0 bit starts at the opposite of the previous bit's final level, and a 1 bit starts at that same level. The second half is always the opposite of the first half.
- R8: Only formats 1 and 4 update the shared reference level, which is the last level they drove. The other formats leave it unchanged.
- R9: The format input is sampled only at a strobe edge. Changing it during the second half of a bit does not change that bit's symbols.
- R10: When no strobe arrives, the second-half symbol stays on the line and `half_ph` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | High for one cycle when a new bit starts |
| data_in | input | 1 | Data bit, sampled with the strobe |
| mode | input | 3 | Line format code, sampled with the strobe |
| line_sym | output | 2 | Signed line symbol |
| half_ph | output | 1 | 0 during the first half of a bit, 1 during the second half or idle |

## Verification
Each format is driven with mixed bit sequences, including runs of 1s and runs of 0s. The level formats are then told apart by whether a level follows the bit value or the previous level. The biphase formats are told apart by whether a bit starts with a transition. The tests switch formats between bits, which shows whether the shared reference level carries over or stays untouched. The tests also change the format code in the middle of a bit, leave idle gaps between strobes, and use a reserved format code.

// File: rtl/line_encoder.sv
module line_encoder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       data_in,
  input  logic [2:0] mode,
  output logic [1:0] line_sym,
  output logic       half_ph
);
  localparam logic [1:0] SYM_POS  = 2'b01;
  localparam logic [1:0] SYM_NEG  = 2'b11;
  localparam logic [1:0] SYM_ZERO = 2'b00;
  localparam logic [2:0] FMT_NRZL = 3'd0;
  localparam logic [2:0] FMT_NRZI = 3'd1;
  localparam logic [2:0] FMT_RZ   = 3'd2;
  localparam logic [2:0] FMT_MAN  = 3'd3;
  localparam logic [2:0] FMT_DMAN = 3'd4;

  logic       ref_pos, ref_nxt, start_pos;
  logic [1:0] first_sym, second_sym, second_q;

  assign start_pos = data_in ? ref_pos : ~ref_pos;

  always_comb begin
    ref_nxt    = ref_pos;
    first_sym  = data_in ? SYM_NEG : SYM_POS;
    second_sym = first_sym;
    case (mode)
      FMT_NRZI: begin
        ref_nxt    = ref_pos ^ data_in;
        first_sym  = ref_nxt ? SYM_POS : SYM_NEG;
        second_sym = first_sym;
      end
      FMT_RZ: begin
        first_sym  = data_in ? SYM_POS : SYM_NEG;
        second_sym = SYM_ZERO;
      end
      FMT_MAN: begin
        first_sym  = data_in ? SYM_POS : SYM_NEG;
        second_sym = data_in ? SYM_NEG : SYM_POS;
      end
      FMT_DMAN: begin
        ref_nxt    = ~start_pos;
        first_sym  = start_pos ? SYM_POS : SYM_NEG;
        second_sym = start_pos ? SYM_NEG : SYM_POS;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_pos  <= 1'b1;
      line_sym <= SYM_ZERO;
      second_q <= SYM_ZERO;
      half_ph  <= 1'b1;
    end else if (bit_stb) begin
      ref_pos  <= ref_nxt;
      line_sym <= first_sym;
      second_q <= second_sym;
      half_ph  <= 1'b0;
    end else if (!half_ph) begin
      line_sym <= second_q;
      half_ph  <= 1'b1;
    end
  end

  AST_SYM_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    line_sym != 2'b10); // R2
  AST_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> (!half_ph && line_sym != SYM_ZERO)); // R2
  AST_NRZL_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && mode == FMT_NRZL) |=> line_sym == ($past(data_in) ? SYM_NEG : SYM_POS)); // R3
  AST_NRZI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && $past(bit_stb) && $past(mode) == FMT_NRZI) |=> $stable(line_sym)); // R4
  AST_RZ_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && $past(bit_stb) && $past(mode) == FMT_RZ) |=> line_sym == SYM_ZERO); // R5
  AST_BIPHASE_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_stb && $past(bit_stb) && ($past(mode) == FMT_MAN || $past(mode) == FMT_DMAN))
      |=> line_sym == 2'(2'b00 - $past(line_sym))); // R6 R7
endmodule

// File: tb/line_encoder_test.sv
module line_encoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic data_in = 1'b0;
  logic [2:0] mode = 3'd0;
  logic [1:0] line_sym;
  logic half_ph;
  int checks = 0;
  int errors = 0;
  logic bref = 1'b1;
  bit done = 1'b0;

  line_encoder uut (.clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .data_in(data_in),
                    .mode(mode), .line_sym(line_sym), .half_ph(half_ph));

  always #5 clk = ~clk;

  task automatic check(string req, logic [1:0] act_s, logic act_p, logic [1:0] exp_s, logic exp_p);
    checks++;
    if (act_s !== exp_s || act_p !== exp_p) begin
      errors++;
      $display("FAIL %s: sym=%b ph=%b expected sym=%b ph=%b", req, act_s, act_p, exp_s, exp_p);
    end
  endtask

  function automatic logic [1:0] lv(logic pos);
    return pos ? 2'b01 : 2'b11;
  endfunction

  task automatic model(input logic [2:0] m, input logic d, output logic [1:0] e1, output logic [1:0] e2);
    logic st;
    case (m)
      3'd1: begin bref = bref ^ d; e1 = lv(bref); e2 = e1; end
      3'd2: begin e1 = lv(d); e2 = 2'b00; end
      3'd3: begin e1 = lv(d); e2 = lv(!d); end
      3'd4: begin st = d ? bref : !bref; e1 = lv(st); e2 = lv(!st); bref = !st; end
      default: begin e1 = lv(!d); e2 = e1; end
    endcase
  endtask

  task automatic send(string req, input logic [2:0] m, input logic d, input logic [2:0] mid_mode);
    logic [1:0] e1, e2;
    model(m, d, e1, e2);
    @(negedge clk); bit_stb = 1'b1; data_in = d; mode = m;
    @(posedge clk); #1;
    check(req, line_sym, half_ph, e1, 1'b0);
    @(negedge clk); bit_stb = 1'b0; mode = mid_mode; data_in = !d;
    @(posedge clk); #1;
    check(req, line_sym, half_ph, e2, 1'b1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bref = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R1 reset", line_sym, half_ph, 2'b00, 1'b1);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 idle after reset", line_sym, half_ph, 2'b00, 1'b1);
  endtask

  task automatic t_nrzl;
    send("R3 nrzl", 3'd0, 1'b1, 3'd0);
    send("R3 nrzl", 3'd0, 1'b0, 3'd0);
    send("R3 nrzl", 3'd0, 1'b0, 3'd0);
    send("R3 reserved code", 3'd5, 1'b1, 3'd5);
    send("R3 reserved code", 3'd7, 1'b0, 3'd7);
  endtask

  task automatic t_nrzi;
    send("R1 R4 nrzi first 0", 3'd1, 1'b0, 3'd1);
    send("R4 nrzi", 3'd1, 1'b1, 3'd1);
    send("R4 nrzi", 3'd1, 1'b1, 3'd1);
    send("R4 nrzi", 3'd1, 1'b0, 3'd1);
    send("R4 nrzi", 3'd1, 1'b1, 3'd1);
  endtask

  task automatic t_rz;
    send("R5 rz", 3'd2, 1'b1, 3'd2);
    send("R5 rz", 3'd2, 1'b0, 3'd2);
    send("R5 rz", 3'd2, 1'b0, 3'd2);
  endtask

  task automatic t_man;
    send("R6 manchester", 3'd3, 1'b1, 3'd3);
    send("R6 manchester", 3'd3, 1'b0, 3'd3);
    send("R6 manchester", 3'd3, 1'b1, 3'd3);
  endtask

  task automatic t_dman;
    send("R7 diff manchester", 3'd4, 1'b0, 3'd4);
    send("R7 diff manchester", 3'd4, 1'b0, 3'd4);
    send("R7 diff manchester", 3'd4, 1'b1, 3'd4);
    send("R7 diff manchester", 3'd4, 1'b1, 3'd4);
    send("R7 diff manchester", 3'd4, 1'b0, 3'd4);
  endtask

  task automatic t_shared_ref;
    send("R8 nrzi sets ref", 3'd1, 1'b1, 3'd1);
    send("R8 other format", 3'd3, 1'b0, 3'd3);
    send("R8 other format", 3'd0, 1'b0, 3'd0);
    send("R8 ref kept", 3'd4, 1'b1, 3'd4);
    send("R8 dm to nrzi", 3'd1, 1'b0, 3'd1);
  endtask

  task automatic t_mode_mid;
    send("R9 mode change mid-bit", 3'd3, 1'b1, 3'd0);
    send("R9 mode change mid-bit", 3'd2, 1'b0, 3'd3);
    send("R9 mode change mid-bit", 3'd0, 1'b1, 3'd2);
  endtask

  task automatic t_idle;
    send("R10 before idle", 3'd3, 1'b0, 3'd3);
    repeat (3) @(posedge clk);
    #1 check("R10 idle hold", line_sym, half_ph, 2'b01, 1'b1);
    send("R10 before idle", 3'd2, 1'b1, 3'd2);
    repeat (4) @(posedge clk);
    #1 check("R10 idle rz", line_sym, half_ph, 2'b00, 1'b1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_nrzi;
        t_nrzl;
        t_rz;
        t_man;
        t_dman;
        t_shared_ref;
        t_mode_mid;
        t_idle;
        t_reset;
        send("R1 ref restored", 3'd1, 1'b0, 3'd1);
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: done=0 expected done=1");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule